// File: doc/BRIEF.md
# Prescaled Preloadable Base Timer

An 8-bit up-counter driven by a power-of-two prescaler, programmed over a small byte-wide register write port. Software stops the timer, loads a preset, picks one of eight prescale ratios and then starts the count. Each time counting brings the value to its top code (FFh), the block emits a one-cycle overflow event toward an interrupt controller. The counter then rolls over to 00h and keeps counting.

The prescale ratio is the system clock divided by 2^(3+m), where m is the 3-bit mode. The ratio therefore runs from /8 to /1024. At a 6 MHz system clock the shortest tick is about 1.33 µs, and a full 256-count period at /8 is about 341 µs. The prescaler is cleared for as long as the timer is stopped, so the first tick after a start always takes a full prescale period. The counter and control registers cannot be read. The mode register can be read back.

Top module: `base_timer`

## Requirements
- R1: After reset the timer is stopped, the counter holds 00h, the mode is 0 and ovf_o is low. Enabling with no further writes gives the first event 255×8 cycles after the enabling write edge.
- R2: A write to address 0 loads wdata_i into the counter at any time, whether the timer runs or not, and counting continues from the loaded value. A loaded FFh raises no event by itself.
- R3: Address 1 bit 0 is an active-low enable that resets to 1. While it holds 1, the counter keeps its value, the prescaler is held at zero and no event occurs. Writing 0 starts counting, and the bit is a level, not a pulse.
- R4: Address 2 bits [2:0] hold the mode m. One count step takes 2^(3+m) clock cycles. From a start with preset P, the first event comes (255−P)·2^(3+m) cycles after the enabling write edge.
- R5: ovf_o is high for exactly one cycle, the cycle in which counting has just made the counter FFh.
- R6: From FFh the counter wraps to 00h without an event and keeps counting. Successive events are 256·2^(3+m) cycles apart.
- R7: mode_o returns the mode in bits [2:0] with bits [7:3] zero, whatever upper bits were written.
- R8: Writes to address 3 change neither the enable, the mode nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 counter preset, 1 control, 2 mode |
| wdata_i | input | 8 | Write data |
| ovf_o | output | 1 | One-cycle overflow event |
| mode_o | output | 8 | Mode register read-back |

## Verification
A behavioural reference model in the bench predicts both outputs on every cycle. Directed starts cover the reset preset, short and long presets, and the smallest, a middle and the largest prescale. Each start shows the tick length and the count distance separately. A back-to-back event pair tells the wrap period apart from the first-event distance. A stop in mid-count followed by a restart shows that the counter is held but the partial prescale is lost. A preset of FFh loaded while running shows that loading raises no event. Writes with junk upper bits, and writes to the unused address, show that the mode read-back and the stopped state are unaffected.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int ADDR_CNT  = 0;
  localparam int ADDR_CTL  = 1;
  localparam int ADDR_MODE = 2;
endpackage

// File: rtl/bt_ctrl_regs.sv
module bt_ctrl_regs #(
  parameter int CNT_W  = 8,
  parameter int MODE_W = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic              stop_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  mode_rd_o
);
  logic wr_ctl, wr_mode;

  assign wr_ctl     = wr_en_i && (addr_i == ADDR_W'(bt_pkg::ADDR_CTL));
  assign wr_mode    = wr_en_i && (addr_i == ADDR_W'(bt_pkg::ADDR_MODE));
  assign load_o     = wr_en_i && (addr_i == ADDR_W'(bt_pkg::ADDR_CNT));
  assign load_val_o = wdata_i;
  assign mode_rd_o  = {{(CNT_W-MODE_W){1'b0}}, mode_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o <= 1'b1;
      mode_o <= '0;
    end else begin
      if (wr_ctl)  stop_o <= wdata_i[0];
      if (wr_mode) mode_o <= wdata_i[MODE_W-1:0];
    end
  end

  always_comb begin
    assert_mode_upper_zero_R7: assert (mode_rd_o[CNT_W-1:MODE_W] == '0);
  end

  assert_other_addr_keeps_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ctl && !wr_mode) |=> ($stable(stop_o) && $stable(mode_o)));
endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int MODE_W     = 3,
  parameter int SHIFT_BASE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              tick_o
);
  localparam int NUM_MODES = 1 << MODE_W;
  localparam int PSC_W     = SHIFT_BASE + NUM_MODES - 1;

  logic [PSC_W-1:0]     psc_q;
  logic [NUM_MODES-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (stop_i) psc_q <= '0;
    else             psc_q <= psc_q + 1'b1;
  end

  // one terminal-count detector per prescale ratio
  for (genvar g = 0; g < NUM_MODES; g++) begin : g_hit
    assign hit[g] = &psc_q[SHIFT_BASE+g-1:0];
  end

  assign tick_o = !stop_i && hit[mode_i];

  assert_stop_clears_psc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (psc_q == '0));
  assert_tick_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (load_i)      cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      // event only when counting lands on the top value
      ovf_o <= tick_i && !load_i && (cnt_q == TOP - 1'b1);
    end
  end

  assert_ovf_at_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt_q == TOP));
  assert_ovf_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
  assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  assert_hold_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
  assert_wrap_to_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_i && cnt_q == TOP) |=> (cnt_q == '0 && !ovf_o));
endmodule

// File: rtl/base_timer.sv
module base_timer #(
  parameter int CNT_W      = 8,
  parameter int MODE_W     = 3,
  parameter int SHIFT_BASE = 3,
  parameter int ADDR_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic              ovf_o,
  output logic [CNT_W-1:0]  mode_o
);
  logic              stop;
  logic [MODE_W-1:0] mode;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              tick;

  bt_ctrl_regs #(.CNT_W(CNT_W), .MODE_W(MODE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .stop_o     (stop),
    .mode_o     (mode),
    .load_o     (load),
    .load_val_o (load_val),
    .mode_rd_o  (mode_o)
  );

  bt_prescaler #(.MODE_W(MODE_W), .SHIFT_BASE(SHIFT_BASE)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stop_i (stop),
    .mode_i (mode),
    .tick_o (tick)
  );

  bt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load),
    .load_val_i (load_val),
    .ovf_o      (ovf_o)
  );
endmodule

// File: tb/base_timer_tb.sv
`timescale 1ns/1ps
module base_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ovf;
  logic [7:0] mode_rd;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  base_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .ovf_o(ovf), .mode_o(mode_rd)
  );

  // behavioural reference model
  int m_cnt, m_psc, m_mode, m_stop, m_ovf;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_psc = 0; m_mode = 0; m_stop = 1; m_ovf = 0;
    end else begin
      int per;
      bit tk, ld;
      per = 1 << (3 + m_mode);
      tk  = (m_stop == 0) && ((m_psc % per) == per - 1);
      ld  = we && addr == 2'd0;
      m_ovf = (tk && !ld && m_cnt == 254) ? 1 : 0;
      m_psc = m_stop ? 0 : (m_psc + 1) % 1024;
      if (ld) m_cnt = wdata;
      else if (tk) m_cnt = (m_cnt + 1) % 256;
      if (we && addr == 2'd1) m_stop = wdata[0];
      if (we && addr == 2'd2) m_mode = wdata[2:0];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(ovf == m_ovf[0], "R5 model ovf_o", ovf, m_ovf);
      check(mode_rd == 8'(m_mode), "R7 model mode_o", mode_rd, m_mode);
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_ovf(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (ovf) begin n = i; break; end
    end
  endtask

  task automatic count_ovf(input int cycles, output int k);
    k = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ovf) k++;
    end
  endtask

  task automatic start_case(input int m, input int pre, input string tag);
    int n, exp;
    wr(2'd1, 8'h01);
    wr(2'd0, 8'(pre));
    wr(2'd2, 8'(m) | 8'hF8);
    check(mode_rd == 8'(m), "R7 junk upper bits", mode_rd, m);
    wr(2'd1, 8'h00);
    exp = (255 - pre) << (3 + m);
    wait_ovf(exp + 10, n);
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    int n, k;
    repeat (3) @(negedge clk);
    check(ovf == 1'b0, "R1 reset ovf_o", ovf, 0);
    check(mode_rd == 8'h00, "R1 reset mode_o", mode_rd, 0);
    rst_n = 1'b1;
    count_ovf(50, k);
    check(k == 0, "R3 stopped after reset", k, 0);

    wr(2'd1, 8'h00);
    wait_ovf(2100, n);
    check(n == 2040, "R1 first event from zero", n, 2040);
    wait_ovf(2100, n);
    check(n == 2048, "R6 wrap period /8", n, 2048);
    @(negedge clk);
    check(ovf == 1'b0, "R5 single-cycle pulse", ovf, 0);

    start_case(0, 8'hFE, "R4 mode0 preset FE");
    start_case(2, 8'hF0, "R4 mode2 preset F0");
    start_case(7, 8'hFE, "R4 mode7 preset FE");
    start_case(5, 8'h80, "R4 mode5 preset 80");

    // load FF while running: no event from the load itself
    wr(2'd1, 8'h01); wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'hFF);
    count_ovf(30, k);
    check(k == 0, "R2 load FF no event", k, 0);
    // preset while running continues from loaded value
    wr(2'd0, 8'hFC);
    wait_ovf(40, n);
    check(n > 0 && n <= 24, "R2 count from preset", n, 24);

    // stop mid-count: counter held, prescale lost
    wr(2'd1, 8'h01); wr(2'd0, 8'hF0); wr(2'd1, 8'h00);
    repeat (40) @(negedge clk);
    wr(2'd1, 8'h01);
    count_ovf(500, k);
    check(k == 0, "R3 no event while stopped", k, 0);
    wr(2'd1, 8'h00);
    wait_ovf(200, n);
    check(n > 0 && n <= 120, "R3 counter held over stop", n, 120);

    // unused address
    wr(2'd1, 8'h01); wr(2'd2, 8'h03);
    wr(2'd3, 8'h00);
    check(mode_rd == 8'h03, "R8 addr3 keeps mode", mode_rd, 3);
    count_ovf(300, k);
    check(k == 0, "R8 addr3 keeps stop", k, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule